// File: doc/BRIEF.md
# Wake Event Output Controller

This block turns wake events into a single power-management output pin. It takes four wake sources: a wake-up frame received, a magic packet received, a link that went from down to up, and one spare source. Each source has its own enable bit. An enabled event sets a sticky pending flag. The output pin shows the pending state, and the host selects its active level.

A single 16-bit control word sets up the block. Through it the host picks the output level, enables the sources, and clears pending flags by writing ones to them. The host can also tell the pin to stay inactive until the device clocks report ready for host access. That hold-back applies only while auto wake-up is also enabled. This lets a sleeping device hold its wake request until it can actually answer the host. The event detectors and any clock gating are outside this block.

Top module: `wake_evt_ctrl`

## Requirements
- R1: While `rst` is high and after its release, every control field and pending flag is 0, `cfg_rdata` reads 0x0000 and `wake_o` is 1 (inactive at polarity 0).
- R2: A write sets the fields hold-back (bit 14), polarity (bit 12), source enables (bits 11:8) and auto wake-up (bit 7), and each reads back as written. Bits 15, 13 and 6:4 always read 0. Bits 3:0 read the pending flags.
- R3: Event input bit i is paired with enable bit 8+i and pending bit i. Input bit 3 is the wake-up frame, bit 2 the magic packet, bit 1 link down-to-up and bit 0 the spare source. A pulse on an enabled source sets its pending flag at that clock edge.
- R4: A pulse on a source whose enable bit is 0 never sets its pending flag and never changes `wake_o`.
- R5: A pending flag stays set until a write with a 1 in its bit position. Writing 0 there leaves it set. If an enabled event and a clear hit the same flag in the same cycle, the flag stays set.
- R6: `wake_o` is registered. One clock edge after any pending flag is seen and no hold-back applies, it equals the polarity bit. When no flag is pending it equals the inverse of the polarity bit.
- R7: With hold-back and auto wake-up both 1 and `clk_ready` low, `wake_o` stays at the inactive level even though flags are pending, and the flags stay pending.
- R8: With auto wake-up 0, the hold-back bit has no effect: `wake_o` asserts whatever the value of `clk_ready`.
- R9: A held-back output becomes active on the first clock edge at which `clk_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Write data: control fields, and write-one-to-clear in bits 3:0 |
| cfg_rdata | output | 16 | Read-back of the control fields and the pending flags |
| evt_i | input | 4 | Single-cycle wake event pulses, one per source |
| clk_ready | input | 1 | High when the device clocks are running and ready for host access |
| wake_o | output | 1 | Power-management event output pin |

## Verification
The assertions check on every cycle that pending flags are sticky, that a disabled source cannot raise a flag, that a clear write drops a flag, and that the pin level follows the polarity, the pending state and the hold-back condition. Some behaviour needs whole scenarios and only the bench shows it: the pairing of each event input with its enable and status bit, the field layout on read-back, and the release of a held output on the edge after `clk_ready` rises. The bench sweeps every combination of polarity, auto wake-up, hold-back, enable mask, event mask and clocks-ready level.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int REG_W     = 16;
  localparam int N_SRC     = 4;
  localparam int F_HOLD    = 14;
  localparam int F_POL     = 12;
  localparam int F_EN_LO   = 8;
  localparam int F_AUTO    = 7;
  localparam int F_PEND_LO = 0;

  typedef struct packed {
    logic             hold;
    logic             pol;
    logic             auto_wk;
    logic [N_SRC-1:0] en;
  } wake_cfg_t;
endpackage

// File: rtl/wake_cfg_reg.sv
module wake_cfg_reg
  import wake_pkg::*;
#(
  parameter int W = REG_W,
  parameter int N = N_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [W-1:0]     wdata,
  input  logic [N-1:0]     pend,
  output wake_cfg_t        cfg,
  output logic [N-1:0]     clr,
  output logic [W-1:0]     rdata
);
  localparam int EN_HI = F_EN_LO + N - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr) begin
      cfg.hold    <= wdata[F_HOLD];
      cfg.pol     <= wdata[F_POL];
      cfg.auto_wk <= wdata[F_AUTO];
      cfg.en      <= wdata[EN_HI:F_EN_LO];
    end
  end

  assign clr = wr ? wdata[F_PEND_LO +: N] : '0;

  always_comb begin
    rdata                    = '0;
    rdata[F_HOLD]            = cfg.hold;
    rdata[F_POL]             = cfg.pol;
    rdata[F_AUTO]            = cfg.auto_wk;
    rdata[EN_HI:F_EN_LO]     = cfg.en;
    rdata[F_PEND_LO +: N]    = pend;
  end

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cfg.pol == $past(wdata[F_POL])) && (cfg.hold == $past(wdata[F_HOLD])));
endmodule

// File: rtl/wake_pend.sv
module wake_pend
  import wake_pkg::*;
#(
  parameter int N = N_SRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)                  pend[i] <= 1'b0;
      else if (evt[i] && en[i]) pend[i] <= 1'b1;
      else if (clr[i])          pend[i] <= 1'b0;
    end

    // R4
    pend_off_chk: assert property (@(posedge clk) disable iff (rst)
      (!pend[i] && !en[i]) |=> !pend[i]);
    // R5
    pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (pend[i] && !clr[i]) |=> pend[i]);
    // R5
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !(evt[i] && en[i])) |=> !pend[i]);
    // R3
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && en[i]) |=> pend[i]);
  end
endmodule

// File: rtl/wake_out_gate.sv
module wake_out_gate
  import wake_pkg::*;
#(
  parameter int N = N_SRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  input  wake_cfg_t    cfg,
  input  logic         clk_ready,
  output logic         wake_o
);
  logic any_pend;
  logic held;

  assign any_pend = |pend;
  assign held     = cfg.auto_wk && cfg.hold && !clk_ready;

  always_ff @(posedge clk) begin
    if (rst) wake_o <= 1'b1;
    else     wake_o <= (any_pend && !held) ? cfg.pol : !cfg.pol;
  end

  // R6
  out_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !any_pend |=> (wake_o != $past(cfg.pol)));
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (any_pend && cfg.auto_wk && cfg.hold && !clk_ready) |=> (wake_o != $past(cfg.pol)));
  // R8
  out_nodelay_chk: assert property (@(posedge clk) disable iff (rst)
    (any_pend && !cfg.auto_wk) |=> (wake_o == $past(cfg.pol)));
  // R9
  out_release_chk: assert property (@(posedge clk) disable iff (rst)
    (any_pend && clk_ready) |=> (wake_o == $past(cfg.pol)));
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
  import wake_pkg::*;
#(
  parameter int W = REG_W,
  parameter int N = N_SRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_wr,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  input  logic [N-1:0] evt_i,
  input  logic         clk_ready,
  output logic         wake_o
);
  wake_cfg_t    cfg;
  logic [N-1:0] clr;
  logic [N-1:0] pend;

  wake_cfg_reg #(.W(W), .N(N)) u_reg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .pend(pend), .cfg(cfg), .clr(clr), .rdata(cfg_rdata)
  );

  wake_pend #(.N(N)) u_pend (
    .clk(clk), .rst(rst), .evt(evt_i), .en(cfg.en), .clr(clr), .pend(pend)
  );

  wake_out_gate #(.N(N)) u_gate (
    .clk(clk), .rst(rst), .pend(pend), .cfg(cfg),
    .clk_ready(clk_ready), .wake_o(wake_o)
  );

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (wake_o && pend == '0));
endmodule

// File: tb/test_wake_evt_ctrl.sv
module test_wake_evt_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [3:0]  evt_i = '0;
  logic        clk_ready = 1'b0;
  logic        wake_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  wake_evt_ctrl i_wake_evt_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .evt_i(evt_i), .clk_ready(clk_ready), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] cfg_word(input bit hold, input bit pol,
                                           input bit aw, input logic [3:0] en);
    return {1'b0, hold, 1'b0, pol, en, aw, 7'b0};
  endfunction

  // One vector: program config and clear all flags, pulse events, check.
  task automatic run_vec(input bit hold, input bit pol, input bit aw,
                         input logic [3:0] en, input logic [3:0] ev, input bit cr);
    logic [15:0] w;
    logic [3:0]  pe;
    bit          held;
    w = cfg_word(hold, pol, aw, en);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = w | 16'h000F; evt_i = '0; clk_ready = cr;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
    check("R2", cfg_rdata, w);
    evt_i = ev;
    @(negedge clk);
    evt_i = '0;
    pe = ev & en;
    check(pe != 0 ? "R3" : "R4", {12'b0, cfg_rdata[3:0]}, {12'b0, pe});
    @(negedge clk);
    held = aw && hold && !cr;
    if (pe == 0)   check("R4", {15'b0, wake_o}, {15'b0, !pol});
    else if (held) check("R7", {15'b0, wake_o}, {15'b0, !pol});
    else if (!aw)  check("R8", {15'b0, wake_o}, {15'b0, pol});
    else           check("R6", {15'b0, wake_o}, {15'b0, pol});
    if (pe != 0 && held) begin
      check("R7", {12'b0, cfg_rdata[3:0]}, {12'b0, pe});
      clk_ready = 1'b1;
      @(negedge clk);
      check("R9", {15'b0, wake_o}, {15'b0, pol});
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", cfg_rdata, 16'h0000);
    check("R1", {15'b0, wake_o}, 16'h0001);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {15'b0, wake_o}, 16'h0001);

    // R2: unused bits read 0
    cfg_wr = 1'b1; cfg_wdata = 16'hFFF0;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
    check("R2", cfg_rdata, 16'h5F80);

    // Exhaustive sweep
    for (int h = 0; h < 2; h++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < 2; a++)
          for (int e = 0; e < 16; e++)
            for (int v = 0; v < 16; v++)
              for (int c = 0; c < 2; c++)
                run_vec(h[0], p[0], a[0], e[3:0], v[3:0], c[0]);

    // R5: stickiness, write-zero, partial clear, set-beats-clear
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = cfg_word(0, 1, 0, 4'hF) | 16'h000F; clk_ready = 1'b0;
    @(negedge clk);
    cfg_wr = 1'b0; evt_i = 4'b1010;
    @(negedge clk);
    evt_i = '0;
    repeat (4) @(negedge clk);
    check("R5", {12'b0, cfg_rdata[3:0]}, 16'h000A);
    cfg_wr = 1'b1; cfg_wdata = cfg_word(0, 1, 0, 4'hF);
    @(negedge clk);
    check("R5", {12'b0, cfg_rdata[3:0]}, 16'h000A);
    cfg_wdata = cfg_word(0, 1, 0, 4'hF) | 16'h0008;
    @(negedge clk);
    check("R5", {12'b0, cfg_rdata[3:0]}, 16'h0002);
    cfg_wdata = cfg_word(0, 1, 0, 4'hF) | 16'h0002; evt_i = 4'b0010;
    @(negedge clk);
    cfg_wr = 1'b0; evt_i = '0;
    check("R5", {12'b0, cfg_rdata[3:0]}, 16'h0002);
    check("R6", {15'b0, wake_o}, 16'h0001);
    cfg_wr = 1'b1; cfg_wdata = cfg_word(0, 1, 0, 4'hF) | 16'h000F;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
    check("R6", {15'b0, wake_o}, 16'h0000);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule